// File: doc/BRIEF.md
# Instruction-Selected Multiply-Add Datapath

This block is a pipelined signed arithmetic unit. On each clock, a select code chooses one entry from a list of operations that is fixed when the block is built. An entry can form the difference of D and A and multiply it by B, or multiply A alone by B. A post adder/subtractor then combines the product with a second term. That term comes from zero, the block's own previous result, the C operand or a partial sum arriving from a neighbouring unit. A carry-in joins the sum, and a carry-out leaves with the result.

When the block is built in concatenation mode, the multiplier and the pre-adder are removed. A and B are then joined into one wide signed addend, with A in the upper bits, and the instruction list only chooses the second term and the add/subtract direction. Every operand path has its own register stages, its own clock enable and its own synchronous clear. A global clock enable and a global synchronous clear act on every path. The select code travels alongside the operands, so each instruction meets its own data at the adder.

Top module: `opsel_mac`

## Requirements
- R1: In multiplier mode, an entry whose bit 0 is 0 computes the product (D - A) * B. All operands are two's-complement signed, and the product is sign-extended to the P width.
- R2: An entry whose bit 0 is 1 multiplies A alone by B, and the value on D has no effect on the result.
- R3: Bits 2:1 of an entry pick the second adder term: 0 is zero, 1 is the current P register, 2 is the C operand and 3 is the cascade input `pcin`. The cascade input is taken in the same cycle the result is registered.
- R4: Bit 3 of an entry is 0 for add, giving Z + X + cin, and 1 for subtract, giving Z - X - cin. `carry_out` is bit P_W of the same sum formed on zero-extended P_W+1-bit operands, so it is the carry for add and the borrow for subtract.
- R5: With term source 1, back-to-back instructions accumulate. Each one adds to the result of the instruction that entered one cycle before it.
- R6: `sel` is unsigned and ceil(log2(N_INSTR)) bits wide. It indexes the parameter `INSTR_TAB`, where entry i occupies bits 4i+3:4i.
- R7: With `CONCAT=1`, X is {A, B} sign-extended to the P width, and bit 0 of each entry is ignored.
- R8: The global `sclr` clears every register, including P and `carry_out`, at a rising edge, even when `ce` is low.
- R9: `clr_p` clears only the result register, so results of operations already in the pipeline still appear on the cycles that follow.
- R10: While `ce` is low, every register holds, and P and `carry_out` do not change whatever the inputs do.
- R11: While a path enable is low, for example `ce_c`, only that path's registers hold their values. A value on that input is then ignored until the enable returns.
- R12: `pcout` always equals P.
- R13: Operands and select captured at rising edge k determine P and `carry_out` after rising edge k+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| sclr | input | 1 | Global synchronous clear, overrides all enables |
| ce | input | 1 | Global clock enable |
| ce_a | input | 1 | Enable for A and pre-adder/concat registers |
| ce_b | input | 1 | Enable for B registers |
| ce_c | input | 1 | Enable for C registers |
| ce_d | input | 1 | Enable for D register |
| ce_sel | input | 1 | Enable for select and carry-in registers |
| ce_m | input | 1 | Enable for product register |
| ce_p | input | 1 | Enable for result register |
| clr_a | input | 1 | Clear for A path |
| clr_b | input | 1 | Clear for B path |
| clr_c | input | 1 | Clear for C path |
| clr_d | input | 1 | Clear for D path |
| clr_sel | input | 1 | Clear for select path |
| clr_m | input | 1 | Clear for product register |
| clr_p | input | 1 | Clear for result register |
| d | input | D_W | Pre-adder primary operand |
| a | input | A_W | Pre-adder subtrahend, multiplier operand, upper concat half |
| b | input | B_W | Multiplier factor, lower concat half |
| c | input | P_W | Adder operand |
| pcin | input | P_W | Cascaded partial sum |
| cin | input | 1 | Carry-in |
| sel | input | SEL_W | Instruction index |
| p | output | P_W | Result |
| carry_out | output | 1 | Carry or borrow of the adder |
| pcout | output | P_W | Cascade copy of the result |

## Verification
Two events can meet in one cycle: a `clr_p` pulse and the arrival of an accumulate instruction that would read P. The bench provokes this by pulsing `clr_p` in the middle of random traffic that includes accumulate entries. The reference model zeroes its own result at that edge and keeps its queue of pending operations, so the next accumulation must start from zero. A global `sclr` is also applied while `ce` is low, and the bench judges it on whether clear wins over the frozen pipeline.

// File: rtl/opsel_mac_pkg.sv
package opsel_mac_pkg;

   // Second adder term selection (entry bits 2:1)
   typedef enum logic [1:0] {
      ZSRC_ZERO = 2'd0,
      ZSRC_P    = 2'd1,
      ZSRC_C    = 2'd2,
      ZSRC_CASC = 2'd3
   } zsrc_e;

   localparam int INSTR_BITS = 4;
   localparam int F_AONLY    = 0;
   localparam int F_ZSRC     = 1;
   localparam int F_SUB      = 3;

endpackage

// File: rtl/opsel_mac_reg.sv
module opsel_mac_reg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         sclr,
   input  logic         clr,
   input  logic         ce,
   input  logic         en,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   always_ff @(posedge clk) begin
      if (sclr || clr)
         q <= '0;
      else if (ce && en)
         q <= d;
   end

endmodule

// File: rtl/opsel_mac_front.sv
module opsel_mac_front
   import opsel_mac_pkg::*;
#(
   parameter int                          A_W       = 27,
   parameter int                          B_W       = 18,
   parameter int                          P_W       = 48,
   parameter int                          SEL_W     = 3,
   parameter int                          N_INSTR   = 8,
   parameter logic [N_INSTR*INSTR_BITS-1:0] INSTR_TAB = '0,
   parameter bit                          CONCAT    = 1'b0
) (
   input  logic               clk,
   input  logic               sclr,
   input  logic               ce,
   input  logic               ce_a,
   input  logic               ce_b,
   input  logic               ce_c,
   input  logic               ce_d,
   input  logic               ce_sel,
   input  logic               clr_a,
   input  logic               clr_b,
   input  logic               clr_c,
   input  logic               clr_d,
   input  logic               clr_sel,
   input  logic [A_W-1:0]     d_in,
   input  logic [A_W-1:0]     a_in,
   input  logic [B_W-1:0]     b_in,
   input  logic [P_W-1:0]     c_in,
   input  logic [SEL_W-1:0]   sel_in,
   input  logic               cin_in,
   output logic [A_W:0]       pre2,
   output logic [B_W-1:0]     b2,
   output logic [A_W+B_W-1:0] cat2,
   output logic [P_W-1:0]     c2,
   output logic [SEL_W:0]     s2
);

   localparam int CAT_W = A_W + B_W;

   logic [A_W-1:0]   a1;
   logic [B_W-1:0]   b1;
   logic [P_W-1:0]   c1;
   logic [SEL_W:0]   s1;

   opsel_mac_reg #(.W(A_W)) u_a1 (.clk(clk), .sclr(sclr), .clr(clr_a), .ce(ce), .en(ce_a),
                                  .d(a_in), .q(a1));
   opsel_mac_reg #(.W(B_W)) u_b1 (.clk(clk), .sclr(sclr), .clr(clr_b), .ce(ce), .en(ce_b),
                                  .d(b_in), .q(b1));
   opsel_mac_reg #(.W(P_W)) u_c1 (.clk(clk), .sclr(sclr), .clr(clr_c), .ce(ce), .en(ce_c),
                                  .d(c_in), .q(c1));
   opsel_mac_reg #(.W(P_W)) u_c2 (.clk(clk), .sclr(sclr), .clr(clr_c), .ce(ce), .en(ce_c),
                                  .d(c1), .q(c2));
   opsel_mac_reg #(.W(SEL_W+1)) u_s1 (.clk(clk), .sclr(sclr), .clr(clr_sel), .ce(ce),
                                      .en(ce_sel), .d({sel_in, cin_in}), .q(s1));
   opsel_mac_reg #(.W(SEL_W+1)) u_s2 (.clk(clk), .sclr(sclr), .clr(clr_sel), .ce(ce),
                                      .en(ce_sel), .d(s1), .q(s2));

   generate
      if (CONCAT) begin : g_cat
         logic [CAT_W-1:0] cat_d;
         assign cat_d = {a1, b1};
         opsel_mac_reg #(.W(CAT_W)) u_cat2 (.clk(clk), .sclr(sclr), .clr(clr_a), .ce(ce),
                                            .en(ce_a), .d(cat_d), .q(cat2));
         assign pre2 = '0;
         assign b2   = '0;
         wire unused_front = ^{d_in, ce_d, clr_d};
      end else begin : g_mul
         logic [A_W-1:0]   d1;
         logic [A_W:0]     pre_d;
         logic [SEL_W-1:0] idx1;
         logic             a_only;
         opsel_mac_reg #(.W(A_W)) u_d1 (.clk(clk), .sclr(sclr), .clr(clr_d), .ce(ce),
                                        .en(ce_d), .d(d_in), .q(d1));
         assign idx1   = (int'(s1[SEL_W:1]) < N_INSTR) ? s1[SEL_W:1] : '0;
         assign a_only = INSTR_TAB[int'(idx1)*INSTR_BITS + F_AONLY];
         always_comb begin
            if (a_only)
               pre_d = {a1[A_W-1], a1};
            else
               pre_d = {d1[A_W-1], d1} - {a1[A_W-1], a1};
         end
         opsel_mac_reg #(.W(A_W+1)) u_pre2 (.clk(clk), .sclr(sclr), .clr(clr_a), .ce(ce),
                                            .en(ce_a), .d(pre_d), .q(pre2));
         opsel_mac_reg #(.W(B_W)) u_b2 (.clk(clk), .sclr(sclr), .clr(clr_b), .ce(ce),
                                        .en(ce_b), .d(b1), .q(b2));
         assign cat2 = '0;
      end
   endgenerate

   // A path clear takes effect at the next edge
   p_clear_a_r8: assert property (@(posedge clk) (sclr || clr_a) |=> (a1 == '0));

   // select path holds while its enable is off
   p_hold_sel_r11: assert property (@(posedge clk) disable iff (sclr)
      (!clr_sel && !(ce && ce_sel)) |=> $stable(s1));

endmodule

// File: rtl/opsel_mac_post.sv
module opsel_mac_post
   import opsel_mac_pkg::*;
#(
   parameter int                          A_W       = 27,
   parameter int                          B_W       = 18,
   parameter int                          P_W       = 48,
   parameter int                          SEL_W     = 3,
   parameter int                          N_INSTR   = 8,
   parameter logic [N_INSTR*INSTR_BITS-1:0] INSTR_TAB = '0,
   parameter bit                          CONCAT    = 1'b0
) (
   input  logic               clk,
   input  logic               sclr,
   input  logic               ce,
   input  logic               ce_c,
   input  logic               ce_sel,
   input  logic               ce_m,
   input  logic               ce_p,
   input  logic               clr_c,
   input  logic               clr_sel,
   input  logic               clr_m,
   input  logic               clr_p,
   input  logic [A_W:0]       pre2,
   input  logic [B_W-1:0]     b2,
   input  logic [A_W+B_W-1:0] cat2,
   input  logic [P_W-1:0]     c2,
   input  logic [SEL_W:0]     s2,
   input  logic [P_W-1:0]     pcin,
   output logic [P_W-1:0]     p,
   output logic               co
);

   localparam int M_W = CONCAT ? (A_W + B_W) : (A_W + 1 + B_W);

   logic [M_W-1:0]   m_d, m3;
   logic [P_W-1:0]   c3;
   logic [SEL_W:0]   s3;
   logic [SEL_W-1:0] idx3;
   zsrc_e            zsrc;
   logic             sub;
   logic [P_W-1:0]   x_op, z_op;
   logic [P_W:0]     sum;

   generate
      if (CONCAT) begin : g_cat
         assign m_d = cat2;
         wire unused_post = ^{pre2, b2};
      end else begin : g_mul
         assign m_d = $signed(pre2) * $signed(b2);
         wire unused_post = ^{cat2};
      end
   endgenerate

   opsel_mac_reg #(.W(M_W)) u_m3 (.clk(clk), .sclr(sclr), .clr(clr_m), .ce(ce), .en(ce_m),
                                  .d(m_d), .q(m3));
   opsel_mac_reg #(.W(P_W)) u_c3 (.clk(clk), .sclr(sclr), .clr(clr_c), .ce(ce), .en(ce_c),
                                  .d(c2), .q(c3));
   opsel_mac_reg #(.W(SEL_W+1)) u_s3 (.clk(clk), .sclr(sclr), .clr(clr_sel), .ce(ce),
                                      .en(ce_sel), .d(s2), .q(s3));

   assign idx3 = (int'(s3[SEL_W:1]) < N_INSTR) ? s3[SEL_W:1] : '0;
   assign zsrc = zsrc_e'(INSTR_TAB[int'(idx3)*INSTR_BITS + F_ZSRC +: 2]);
   assign sub  = INSTR_TAB[int'(idx3)*INSTR_BITS + F_SUB];
   assign x_op = {{(P_W-M_W){m3[M_W-1]}}, m3};

   always_comb begin
      unique case (zsrc)
         ZSRC_P:    z_op = p;
         ZSRC_C:    z_op = c3;
         ZSRC_CASC: z_op = pcin;
         default:   z_op = '0;
      endcase
      if (sub)
         sum = {1'b0, z_op} - {1'b0, x_op} - {{P_W{1'b0}}, s3[0]};
      else
         sum = {1'b0, z_op} + {1'b0, x_op} + {{P_W{1'b0}}, s3[0]};
   end

   opsel_mac_reg #(.W(P_W+1)) u_p (.clk(clk), .sclr(sclr), .clr(clr_p), .ce(ce), .en(ce_p),
                                   .d(sum), .q({co, p}));

   // result clear: P and carry both zero after the edge
   p_clear_p_r9: assert property (@(posedge clk) (sclr || clr_p) |=> (p == '0 && !co));

   // result register frozen when not enabled
   p_hold_p_r10: assert property (@(posedge clk) disable iff (sclr)
      (!clr_p && !(ce && ce_p)) |=> ($stable(p) && $stable(co)));

endmodule

// File: rtl/opsel_mac.sv
module opsel_mac
   import opsel_mac_pkg::*;
#(
   parameter int                          A_W       = 27,
   parameter int                          D_W       = 27,
   parameter int                          B_W       = 18,
   parameter int                          P_W       = 48,
   parameter int                          N_INSTR   = 8,
   parameter logic [N_INSTR*INSTR_BITS-1:0] INSTR_TAB = 32'h1E7DA240,
   parameter bit                          CONCAT    = 1'b0,
   localparam int                         SEL_W     = $clog2(N_INSTR)
) (
   input  logic             clk,
   input  logic             sclr,
   input  logic             ce,
   input  logic             ce_a,
   input  logic             ce_b,
   input  logic             ce_c,
   input  logic             ce_d,
   input  logic             ce_sel,
   input  logic             ce_m,
   input  logic             ce_p,
   input  logic             clr_a,
   input  logic             clr_b,
   input  logic             clr_c,
   input  logic             clr_d,
   input  logic             clr_sel,
   input  logic             clr_m,
   input  logic             clr_p,
   input  logic [D_W-1:0]   d,
   input  logic [A_W-1:0]   a,
   input  logic [B_W-1:0]   b,
   input  logic [P_W-1:0]   c,
   input  logic [P_W-1:0]   pcin,
   input  logic             cin,
   input  logic [SEL_W-1:0] sel,
   output logic [P_W-1:0]   p,
   output logic             carry_out,
   output logic [P_W-1:0]   pcout
);

   generate
      if (D_W != A_W) begin : g_bad_dw
         $error("opsel_mac: D_W must equal A_W");
      end
      if (N_INSTR < 2) begin : g_bad_n
         $error("opsel_mac: N_INSTR must be at least 2");
      end
      if (!CONCAT && (A_W + 1 + B_W > P_W)) begin : g_bad_mul
         $error("opsel_mac: product does not fit in P_W");
      end
      if (CONCAT && (A_W + B_W > P_W)) begin : g_bad_cat
         $error("opsel_mac: concatenated operand does not fit in P_W");
      end
   endgenerate

   logic [A_W:0]       pre2;
   logic [B_W-1:0]     b2;
   logic [A_W+B_W-1:0] cat2;
   logic [P_W-1:0]     c2;
   logic [SEL_W:0]     s2;

   opsel_mac_front #(
      .A_W(A_W), .B_W(B_W), .P_W(P_W), .SEL_W(SEL_W), .N_INSTR(N_INSTR),
      .INSTR_TAB(INSTR_TAB), .CONCAT(CONCAT)
   ) u_front (
      .clk(clk), .sclr(sclr), .ce(ce),
      .ce_a(ce_a), .ce_b(ce_b), .ce_c(ce_c), .ce_d(ce_d), .ce_sel(ce_sel),
      .clr_a(clr_a), .clr_b(clr_b), .clr_c(clr_c), .clr_d(clr_d), .clr_sel(clr_sel),
      .d_in(d), .a_in(a), .b_in(b), .c_in(c), .sel_in(sel), .cin_in(cin),
      .pre2(pre2), .b2(b2), .cat2(cat2), .c2(c2), .s2(s2)
   );

   opsel_mac_post #(
      .A_W(A_W), .B_W(B_W), .P_W(P_W), .SEL_W(SEL_W), .N_INSTR(N_INSTR),
      .INSTR_TAB(INSTR_TAB), .CONCAT(CONCAT)
   ) u_post (
      .clk(clk), .sclr(sclr), .ce(ce),
      .ce_c(ce_c), .ce_sel(ce_sel), .ce_m(ce_m), .ce_p(ce_p),
      .clr_c(clr_c), .clr_sel(clr_sel), .clr_m(clr_m), .clr_p(clr_p),
      .pre2(pre2), .b2(b2), .cat2(cat2), .c2(c2), .s2(s2), .pcin(pcin),
      .p(p), .co(carry_out)
   );

   assign pcout = p;

endmodule

// File: tb/test_opsel_mac.sv
module test_opsel_mac;

   localparam logic [31:0] TAB = 32'h1E7DA240;

   typedef struct {
      logic [26:0] a, d;
      logic [17:0] b;
      logic [47:0] c;
      logic [2:0]  sel;
      logic        cin;
   } op_t;

   logic clk = 1'b0;
   logic sclr = 1'b1, ce = 1'b1;
   logic ce_a = 1, ce_b = 1, ce_c = 1, ce_d = 1, ce_sel = 1, ce_m = 1, ce_p = 1;
   logic clr_a = 0, clr_b = 0, clr_c = 0, clr_d = 0, clr_sel = 0, clr_m = 0, clr_p = 0;
   logic [26:0] d = '0, a = '0;
   logic [17:0] b = '0;
   logic [47:0] c = '0, pcin = '0;
   logic        cin = 1'b0;
   logic [2:0]  sel = '0;
   logic [47:0] p0, p1, pc0, pc1;
   logic        co0, co1;

   int tests = 0, fails = 0;
   bit chk_en = 1'b0;

   always #4 clk = ~clk;

   opsel_mac i_opsel_mac (
      .clk(clk), .sclr(sclr), .ce(ce), .ce_a(ce_a), .ce_b(ce_b), .ce_c(ce_c), .ce_d(ce_d),
      .ce_sel(ce_sel), .ce_m(ce_m), .ce_p(ce_p), .clr_a(clr_a), .clr_b(clr_b), .clr_c(clr_c),
      .clr_d(clr_d), .clr_sel(clr_sel), .clr_m(clr_m), .clr_p(clr_p), .d(d), .a(a), .b(b),
      .c(c), .pcin(pcin), .cin(cin), .sel(sel), .p(p0), .carry_out(co0), .pcout(pc0));

   opsel_mac #(.CONCAT(1'b1)) i_opsel_mac_cat (
      .clk(clk), .sclr(sclr), .ce(ce), .ce_a(ce_a), .ce_b(ce_b), .ce_c(ce_c), .ce_d(ce_d),
      .ce_sel(ce_sel), .ce_m(ce_m), .ce_p(ce_p), .clr_a(clr_a), .clr_b(clr_b), .clr_c(clr_c),
      .clr_d(clr_d), .clr_sel(clr_sel), .clr_m(clr_m), .clr_p(clr_p), .d(d), .a(a), .b(b),
      .c(c), .pcin(pcin), .cin(cin), .sel(sel), .p(p1), .carry_out(co1), .pcout(pc1));

   // ---------------- reference model ----------------
   op_t         q0[$], q1[$];
   logic [47:0] pm0 = '0, pm1 = '0;
   logic        cm0 = 1'b0, cm1 = 1'b0;
   string       tag0 = "R13", tag1 = "R7";

   task automatic calc(input op_t o, input bit cat, input logic [47:0] pprev,
                       input logic [47:0] casc, output logic [47:0] r, output logic co,
                       output string tg);
      logic [3:0]  e;
      longint      xs, m;
      logic [47:0] x48, z;
      logic [48:0] s;
      e = TAB[o.sel*4 +: 4];
      if (cat) begin
         xs = longint'($signed(o.a)) * 262144 + longint'(o.b);
         tg = "R7";
      end else begin
         m  = e[0] ? longint'($signed(o.a))
                   : longint'($signed(o.d)) - longint'($signed(o.a));
         xs = m * longint'($signed(o.b));
         tg = e[0] ? "R2" : ((e[2:1] == 2'd1) ? "R5" : "R1");
      end
      x48 = xs[47:0];
      case (e[2:1])
         2'd1:    z = pprev;
         2'd2:    z = o.c;
         2'd3:    z = casc;
         default: z = '0;
      endcase
      if (e[3]) s = {1'b0, z} - {1'b0, x48} - 49'(o.cin);
      else      s = {1'b0, z} + {1'b0, x48} + 49'(o.cin);
      r  = s[47:0];
      co = s[48];
   endtask

   always @(posedge clk) begin
      op_t         cur, o;
      logic [47:0] r;
      logic        co;
      string       tg;
      cur.a = a; cur.d = d; cur.b = b; cur.c = c; cur.sel = sel; cur.cin = cin;
      if (sclr) begin
         q0.delete(); q1.delete();
         pm0 = '0; pm1 = '0; cm0 = 1'b0; cm1 = 1'b0;
      end else if (ce) begin
         q0.push_back(cur);
         q1.push_back(cur);
         if (q0.size() == 4) begin
            o = q0.pop_front();
            calc(o, 1'b0, pm0, pcin, r, co, tg);
            tag0 = tg;
            if (clr_p) begin pm0 = '0; cm0 = 1'b0; end
            else begin pm0 = r; cm0 = co; end
         end else if (clr_p) begin pm0 = '0; cm0 = 1'b0; end
         if (q1.size() == 4) begin
            o = q1.pop_front();
            calc(o, 1'b1, pm1, pcin, r, co, tg);
            tag1 = tg;
            if (clr_p) begin pm1 = '0; cm1 = 1'b0; end
            else begin pm1 = r; cm1 = co; end
         end else if (clr_p) begin pm1 = '0; cm1 = 1'b0; end
      end else if (clr_p) begin
         pm0 = '0; pm1 = '0; cm0 = 1'b0; cm1 = 1'b0;
      end
   end

   task automatic check(input string req, input logic [48:0] act, input logic [48:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (chk_en) begin
         check({tag0, " R3 R4 R6 R13 mul"}, {co0, p0}, {cm0, pm0});
         check({tag1, " R3 R4 R6 R13 cat"}, {co1, p1}, {cm1, pm1});
         check("R12 pcout", {1'b0, pc0}, {1'b0, p0});
         check("R12 pcout cat", {1'b0, pc1}, {1'b0, p1});
      end
   end

   task automatic rand_in();
      d    = 27'($urandom);
      a    = 27'($urandom);
      b    = 18'($urandom);
      c    = {16'($urandom), 32'($urandom)};
      pcin = {16'($urandom), 32'($urandom)};
      cin  = 1'($urandom);
      sel  = 3'($urandom);
   endtask

   task automatic set_op(input logic [2:0] s, input logic [26:0] dv, input logic [26:0] av,
                         input logic [17:0] bv, input logic [47:0] cv, input logic ci);
      sel = s; d = dv; a = av; b = bv; c = cv; cin = ci; pcin = '0;
   endtask

   task automatic do_clear();
      @(negedge clk);
      sclr = 1'b1;
      repeat (2) @(negedge clk);
      sclr = 1'b0;
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   // ---------------- stimulus ----------------
   initial begin
      logic [47:0] held;
      logic        heldc;
      repeat (3) @(negedge clk);
      check("R8 reset p", {co0, p0}, 49'd0);
      check("R8 reset cat", {co1, p1}, 49'd0);
      sclr = 1'b0;
      chk_en = 1'b1;

      // R13: single op latency, (3-1)*5 = 10
      set_op(3'd0, 27'd3, 27'd1, 18'd5, '0, 1'b0);
      @(negedge clk);
      set_op(3'd0, '0, '0, '0, '0, 1'b0);
      @(negedge clk);
      @(negedge clk);
      check("R13 before edge k+3", {1'b0, p0}, 49'd0);
      @(negedge clk);
      check("R13 R1 at edge k+3", {1'b0, p0}, 49'd10);

      // R5: six accumulations of (5-2)*3 = 9
      do_clear();
      set_op(3'd2, 27'd5, 27'd2, 18'd3, '0, 1'b0);
      repeat (6) @(negedge clk);
      b = '0;
      repeat (8) @(negedge clk);
      check("R5 accumulate total", {1'b0, p0}, 49'd54);

      // R4: A-only add of -1*1 with carry-in 1 wraps to zero with carry
      do_clear();
      set_op(3'd7, 27'd0, '1, 18'd1, '0, 1'b1);
      @(negedge clk);
      set_op(3'd0, '0, '0, '0, '0, 1'b0);
      repeat (3) @(negedge clk);
      check("R4 carry out on wrap", {co0, p0}, {1'b1, 48'd0});

      // R2: D is ignored in A-only mode: 7*(-2) via entry 7
      do_clear();
      set_op(3'd7, 27'h5A5A5A5, 27'd7, 18'h3FFFE, '0, 1'b0);
      @(negedge clk);
      set_op(3'd0, '0, '0, '0, '0, 1'b0);
      repeat (3) @(negedge clk);
      check("R2 A-only product", {1'b0, p0}, {1'b0, 48'hFFFF_FFFF_FFF2});

      // random traffic over all entries
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         rand_in();
         if (i == 200) clr_p = 1'b1;
         else clr_p = 1'b0;
         if (i == 201) check("R9 clr_p zero", {co0, p0}, 49'd0);
      end

      // R10: global enable low freezes everything
      @(negedge clk);
      ce = 1'b0;
      clr_p = 1'b0;
      held = p0;
      heldc = co0;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         rand_in();
      end
      check("R10 frozen p", {co0, p0}, {heldc, held});

      // R8: clear wins while enable is low
      sclr = 1'b1;
      @(negedge clk);
      sclr = 1'b0;
      check("R8 clear over ce", {co0, p0}, 49'd0);
      check("R8 clear over ce cat", {co1, p1}, 49'd0);
      ce = 1'b1;
      for (int i = 0; i < 300; i++) begin
         @(negedge clk);
         rand_in();
      end

      // R11: C path enable off holds old C, model paused
      chk_en = 1'b0;
      do_clear();
      set_op(3'd4, '0, '0, '0, 48'h1234_5678_9ABC, 1'b0);
      repeat (6) @(negedge clk);
      ce_c = 1'b0;
      c = 48'hDEAD_BEEF_0001;
      repeat (6) @(negedge clk);
      check("R11 C held mul", {1'b0, p0}, {1'b0, 48'h1234_5678_9ABC});
      check("R11 C held cat", {1'b0, p1}, {1'b0, 48'h1234_5678_9ABC});
      ce_c = 1'b1;
      repeat (6) @(negedge clk);
      check("R11 C resumes", {1'b0, p0}, {1'b0, 48'hDEAD_BEEF_0001});

      do_clear();
      chk_en = 1'b1;
      for (int i = 0; i < 100; i++) begin
         @(negedge clk);
         rand_in();
      end
      @(negedge clk);
      chk_en = 1'b0;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule